// File: doc/BRIEF.md
# Serial Flash Pin-Pattern Reset Sequencer

This block puts a serial flash device back into its power-on state without using a dedicated reset pin and without sending an opcode. After one start pulse it takes over the chip-select, clock and data-zero lines of the flash. It then steps through a fixed pattern of eight phases. Chip-select toggles and the data-zero line changes level during the pattern, but the clock never moves. Because the clock stays low, the flash cannot read any of this as a command. A flash that supports the standardised pin-level reset recognises the pattern and resets.

Every phase lasts the same number of clock cycles. That length comes from a length input, which the block captures when it accepts a start. A normal SPI master can share the flash pins with this block through an external multiplexer. The `mux_en` output selects this block's levels for the duration of a sequence. The control side is plain: `start` is a single-cycle request, `busy` shows that a sequence is running, and `done` marks its end. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_rst_seq`

## Requirements
- R1: After reset and between sequences the outputs are `busy`=0, `done`=0, `mux_en`=0, `cs_n`=1, `sck`=0 and `io0`=0.
- R2: When `start` is high at a clock edge while `busy` is 0, the sequence is accepted. From that edge on, `busy`=1 and `mux_en`=1.
- R3: Across the eight phases, numbered 0 to 7, `cs_n` takes the levels 0,1,0,1,0,1,0,1.
- R4: Across the eight phases, numbered 0 to 7, `io0` takes the levels 0,1,1,0,0,1,1,1.
- R5: Each phase lasts `step_len`+1 clock cycles. The value used is the one present at the accepting edge, and later changes to `step_len` during the run have no effect.
- R6: `sck` is 0 in every cycle, whether the block is idle or running.
- R7: At the edge where phase 7 ends, `busy` and `mux_en` fall and `done` rises. `done` stays high for exactly one cycle. The run therefore lasts 8×(`step_len`+1) cycles.
- R8: A `start` that arrives while `busy` is 1 is ignored. This includes a `start` in the last cycle of phase 7, and the run's levels and length do not change.
- R9: A `start` in the cycle where `done` is high is accepted and begins a new sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the reset pattern |
| step_len | input | CNT_W | Phase length minus one, in clock cycles |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the sequence completes |
| cs_n | output | 1 | Chip-select level for the flash |
| sck | output | 1 | Clock level for the flash (always low) |
| io0 | output | 1 | Data-zero level for the flash |
| mux_en | output | 1 | Selects this block's levels onto the flash pins |

## Verification
Two events can fall in the same cycle: the end of a run and a new start request. The bench holds `start` high through a whole run, including the last cycle of phase 7. It then checks that the run keeps its length and levels and that `busy` is low after `done`, with no hidden restart. In a separate test, the bench raises `start` exactly in the `done` cycle. It expects a new phase 0 on the next cycle and a full second run after that.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int PHASES  = 8;
  localparam int PHASE_W = $clog2(PHASES);
  // bit k = level during phase k
  localparam logic [PHASES-1:0] CS_LEVELS = 8'b1010_1010;
  localparam logic [PHASES-1:0] IO_LEVELS = 8'b1110_0110;
endpackage

// File: rtl/frs_timer.sv
module frs_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   step_len,
  input  logic               expire,
  output logic               tmr_load,
  output logic [CNT_W-1:0]   tmr_val,
  output logic               busy,
  output logic               done,
  output logic [PHASE_W-1:0] phase
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASES - 1);

  logic [CNT_W-1:0] len_q;
  logic             accept, advance;

  assign accept   = start && !busy;
  assign advance  = busy && expire && (phase != LAST);
  assign tmr_load = accept || advance;
  assign tmr_val  = busy ? len_q : step_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= '0;
      len_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        phase <= '0;
        len_q <= step_len;
      end else if (advance) begin
        phase <= phase + 1'b1;
      end else if (busy && expire) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        phase <= '0;
      end
    end
  end
endmodule

// File: rtl/frs_drive.sv
module frs_drive
  import frs_pkg::*;
(
  input  logic               busy,
  input  logic [PHASE_W-1:0] phase,
  output logic               cs_n,
  output logic               sck,
  output logic               io0,
  output logic               mux_en
);
  logic [PHASES-1:0] sel;

  for (genvar k = 0; k < PHASES; k++) begin : g_sel
    assign sel[k] = busy && (phase == PHASE_W'(k));
  end

  assign cs_n   = busy ? |(sel & CS_LEVELS) : 1'b1;
  assign io0    = |(sel & IO_LEVELS);
  assign sck    = 1'b0;
  assign mux_en = busy;
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import frs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] step_len,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             sck,
  output logic             io0,
  output logic             mux_en
);
  logic               tmr_load, expire;
  logic [CNT_W-1:0]   tmr_val;
  logic [PHASE_W-1:0] phase;

  frs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(busy), .expire(expire)
  );

  frs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step_len(step_len),
    .expire(expire), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .busy(busy), .done(done), .phase(phase)
  );

  frs_drive u_drive (
    .busy(busy), .phase(phase), .cs_n(cs_n), .sck(sck), .io0(io0),
    .mux_en(mux_en)
  );
endmodule

// File: rtl/frs_chk.sv
module frs_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic io0,
  input logic mux_en
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !io0 && !mux_en));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mux_en && !cs_n));

  p_first_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!cs_n && !io0));

  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_no_start_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

bind flash_rst_seq frs_chk u_frs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cs_n(cs_n), .io0(io0), .mux_en(mux_en)
);

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;
  localparam int CNT_W = 16;
  localparam logic [7:0] CS_EXP = 8'b1010_1010;
  localparam logic [7:0] IO_EXP = 8'b1110_0110;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] step_len = '0;
  logic busy, done, cs_n, sck, io0, mux_en;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_rst_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step_len(step_len),
    .busy(busy), .done(done), .cs_n(cs_n), .sck(sck), .io0(io0),
    .mux_en(mux_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(busy == 0 && mux_en == 0, {"R1 busy/mux ", tag}, {busy, mux_en}, 0);
    chk(cs_n == 1 && io0 == 0,    {"R1 cs/io0 ", tag}, {cs_n, io0}, 2);
    chk(sck == 0, {"R6 sck idle ", tag}, sck, 0);
  endtask

  // Called at the negedge after the accepting edge; returns at the done negedge.
  task automatic follow_run(input int len, input bit hold_start);
    int l = len + 1;
    for (int i = 0; i < 8 * l; i++) begin
      int ph = i / l;
      if (hold_start) begin start = 1'b1; step_len = CNT_W'(len + 3); end
      chk(busy && mux_en, "R2 busy/mux during run (R5 length)", {busy, mux_en}, 3);
      chk(cs_n == CS_EXP[ph], "R3 cs_n phase level", cs_n, CS_EXP[ph]);
      chk(io0 == IO_EXP[ph],  "R4 io0 phase level", io0, IO_EXP[ph]);
      chk(sck == 0, "R6 sck in run", sck, 0);
      chk(!done, "R7 no early done", done, 0);
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1 && busy == 0, "R7 done with busy low (R8 run length kept)", {done, busy}, 2);
    chk(cs_n == 1 && mux_en == 0, "R7 lines released", {cs_n, mux_en}, 2);
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    step_len = CNT_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk_idle("reset");
    chk(done == 0, "R1 done reset", done, 0);
  endtask

  task automatic t_basic(input int len);
    pulse_start(len);
    follow_run(len, 1'b0);
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
    chk_idle("after run");
  endtask

  task automatic t_busy_start;
    pulse_start(2);
    follow_run(2, 1'b1);
    @(negedge clk);
    chk(busy == 0, "R8 start during run ignored", busy, 0);
    chk_idle("after ignored starts");
  endtask

  task automatic t_restart_on_done;
    pulse_start(1);
    follow_run(1, 1'b0);
    step_len = CNT_W'(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1 && cs_n == 0 && done == 0, "R9 restart in done cycle",
        {busy, cs_n, done}, 4);
    follow_run(0, 1'b0);
    @(negedge clk);
    chk_idle("after restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic(0);
    t_basic(3);
    t_basic(6);
    t_busy_start();
    t_restart_on_done();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule